// File: doc/BRIEF.md
# Odd-Even Merge Sorting Network

This block sorts a group of unsigned keys into ascending order in a single pass through a fixed comparator network. The key count is a power of two and defaults to eight; the key width defaults to eight bits. Keys arrive packed into one flat vector, with key `i` in bits `[i*KEY_W +: KEY_W]`. The sorted group leaves in the same layout, with the smallest key at index 0.

The network is built recursively. A sorter for N keys sorts each half with a sorter of N/2 keys and then joins the halves with an odd-even merger. To merge two sorted lists, the merger merges the even-position keys of both lists into one sequence `v` and the odd-position keys into another sequence `w`. It then compare-exchanges `w[i]` against `v[i+1]`. The first key of `v` is the overall minimum and goes straight through to index 0. For eight keys the network uses 19 compare-exchange cells arranged in 6 levels.

A qualifier bit travels beside the keys. With the default output mode, the sorted keys and the qualifier are captured in one register stage and appear one cycle after the input. While the qualifier is low the captured keys stay as they are.

Top module: `oem_sorter`

## Requirements
- R1: When `in_valid` is high, the keys presented one cycle later on `out_keys` are exactly the input keys reordered so that each index holds a key no larger than the one at the next higher index.
- R2: For every one of the 2^N input patterns in which each key is either 0 or 1, the output holds all zeros at the low indices and all ones above them, with the count of ones preserved.
- R3: Equal keys are handled correctly: repeated values all appear in the output, and an input of identical keys comes out unchanged.
- R4: Keys are compared as unsigned numbers. A key of all ones lands at the highest index, and a key of zero lands at the lowest index.
- R5: `out_valid` equals the value `in_valid` had one clock cycle earlier.
- R6: While `in_valid` is low, `out_keys` keeps its previous value, whatever is on `in_keys`.
- R7: A synchronous active-high `rst` clears `out_valid` to 0 and `out_keys` to all zeros at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input keys are meaningful this cycle |
| in_keys | input | N_KEYS*KEY_W | Unsorted keys; key i at bits [i*KEY_W +: KEY_W] |
| out_valid | output | 1 | Delayed copy of in_valid |
| out_keys | output | N_KEYS*KEY_W | Sorted keys, smallest at index 0 |

## Verification
The clocked properties assume that `in_keys` and `in_valid` hold known values at every rising edge after reset. The merge-order check assumes the two halves fed to each merger are already ordered, and it tests only the cycles in which that holds. The bench drives every input on the falling edge and keeps `rst` high across at least one rising edge, so each edge samples stable, defined values. It covers the full set of zero-one patterns as well as random multi-bit keys.

// File: rtl/oem_pkg.sv
package oem_pkg;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_FLOP = 1'b1
    } out_mode_e;

    function automatic int unsigned lg2(input int unsigned v);
        int unsigned r;
        r = 0;
        while ((32'd1 << r) < v) r++;
        return r;
    endfunction

endpackage

// File: rtl/oem_cmpx.sv
module oem_cmpx #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic swap;

    assign swap = (a > b);

    always_comb begin
        if (swap) begin
            lo = b;
            hi = a;
        end else begin
            lo = a;
            hi = b;
        end
    end
endmodule

// File: rtl/oem_merge.sv
module oem_merge #(
    parameter int W = 8,
    parameter int M = 4
) (
    input  logic [2*M-1:0][W-1:0] din,
    output logic [2*M-1:0][W-1:0] dout
);
    function automatic logic is_asc(input logic [2*M-1:0][W-1:0] d,
                                    input int first, input int last);
        logic ok;
        ok = 1'b1;
        for (int k = first; k < last; k++) begin
            if (d[k] > d[k+1]) ok = 1'b0;
        end
        return ok;
    endfunction

    generate
        if (M == 1) begin : g_base
            oem_cmpx #(.W(W)) u_cx (
                .a (din[0]),
                .b (din[1]),
                .lo(dout[0]),
                .hi(dout[1])
            );
        end else begin : g_rec
            logic [M-1:0][W-1:0] ev_in, od_in, v, w;

            for (genvar i = 0; i < M/2; i++) begin : g_split
                assign ev_in[i]       = din[2*i];
                assign ev_in[M/2 + i] = din[M + 2*i];
                assign od_in[i]       = din[2*i + 1];
                assign od_in[M/2 + i] = din[M + 2*i + 1];
            end

            oem_merge #(.W(W), .M(M/2)) u_even (.din(ev_in), .dout(v));
            oem_merge #(.W(W), .M(M/2)) u_odd  (.din(od_in), .dout(w));

            assign dout[0]       = v[0];
            assign dout[2*M - 1] = w[M-1];

            for (genvar i = 0; i < M - 1; i++) begin : g_fix
                oem_cmpx #(.W(W)) u_cx (
                    .a (w[i]),
                    .b (v[i+1]),
                    .lo(dout[2*i + 1]),
                    .hi(dout[2*i + 2])
                );
            end
        end
    endgenerate

    always_comb begin
        if (!$isunknown(din) && is_asc(din, 0, M-1) && is_asc(din, M, 2*M-1)) begin
            // R2
            merge_order_chk: assert (is_asc(dout, 0, 2*M-1));
        end
    end
endmodule

// File: rtl/oem_sort.sv
module oem_sort #(
    parameter int W = 8,
    parameter int N = 8
) (
    input  logic [N-1:0][W-1:0] din,
    output logic [N-1:0][W-1:0] dout
);
    generate
        if (N == 1) begin : g_leaf
            assign dout = din;
        end else begin : g_rec
            localparam int H = N / 2;
            logic [N-1:0][W-1:0] halves;

            oem_sort #(.W(W), .N(H)) u_low (
                .din (din[H-1:0]),
                .dout(halves[H-1:0])
            );
            oem_sort #(.W(W), .N(H)) u_high (
                .din (din[N-1:H]),
                .dout(halves[N-1:H])
            );
            oem_merge #(.W(W), .M(H)) u_join (
                .din (halves),
                .dout(dout)
            );
        end
    endgenerate
endmodule

// File: rtl/oem_sorter.sv
module oem_sorter #(
    parameter int                  KEY_W    = 8,
    parameter int                  N_KEYS   = 8,
    parameter oem_pkg::out_mode_e  OUT_MODE = oem_pkg::OUT_FLOP
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [N_KEYS*KEY_W-1:0]   in_keys,
    output logic                      out_valid,
    output logic [N_KEYS*KEY_W-1:0]   out_keys
);
    localparam int LG_N  = oem_pkg::lg2(N_KEYS);
    localparam int SUM_W = KEY_W + LG_N + 1;

    if ((1 << LG_N) != N_KEYS) begin : g_bad_n
        $error("N_KEYS must be a power of two");
    end

    logic [N_KEYS-1:0][KEY_W-1:0] net_in, net_out;

    assign net_in = in_keys;

    oem_sort #(.W(KEY_W), .N(N_KEYS)) u_net (
        .din (net_in),
        .dout(net_out)
    );

    function automatic logic [SUM_W-1:0] key_sum(input logic [N_KEYS*KEY_W-1:0] v);
        logic [SUM_W-1:0] s;
        s = '0;
        for (int k = 0; k < N_KEYS; k++) s += SUM_W'(v[k*KEY_W +: KEY_W]);
        return s;
    endfunction

    generate
        if (OUT_MODE == oem_pkg::OUT_FLOP) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    out_keys  <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) out_keys <= net_out;
                end
            end

            for (genvar i = 0; i < N_KEYS - 1; i++) begin : g_ord
                // R1
                sort_order_chk: assert property (@(posedge clk) disable iff (rst)
                    out_valid |-> (out_keys[i*KEY_W +: KEY_W] <= out_keys[(i+1)*KEY_W +: KEY_W]));
            end

            // R1
            key_sum_chk: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> (key_sum(out_keys) == $past(key_sum(in_keys))));

            // R5
            valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (out_valid == $past(in_valid)));

            // R6
            hold_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(out_keys));

            // R7
            reset_chk: assert property (@(posedge clk)
                rst |=> (!out_valid && out_keys == '0));
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_keys  = net_out;
        end
    endgenerate
endmodule

// File: tb/tb_oem_sorter.sv
module tb_oem_sorter;
    localparam int W  = 8;
    localparam int N  = 8;
    localparam int NV = 6;
    localparam int WATCHDOG_CYCLES = 20000;

    localparam logic [N*W-1:0] VEC_IN [NV] = '{
        64'h0102030405060708,
        64'h0807060504030201,
        64'h5555555555555555,
        64'h00FF00FF00FF00FF,
        64'h80017F0280FE0180,
        64'h00000000000000FF
    };
    localparam logic [N*W-1:0] VEC_EXP [NV] = '{
        64'h0807060504030201,
        64'h0807060504030201,
        64'h5555555555555555,
        64'hFFFFFFFF00000000,
        64'hFE8080807F020101,
        64'hFF00000000000000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [N*W-1:0] in_keys = '0;
    logic out_valid;
    logic [N*W-1:0] out_keys;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    oem_sorter #(.KEY_W(W), .N_KEYS(N)) dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_keys  (in_keys),
        .out_valid(out_valid),
        .out_keys (out_keys)
    );

    function automatic string vec_tag(input int i);
        case (i)
            2: return "R3";
            3, 5: return "R4";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
        logic [W-1:0] a [N];
        logic [W-1:0] t;
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N - 1 - i; j++)
                if (a[j] > a[j+1]) begin
                    t = a[j]; a[j] = a[j+1]; a[j+1] = t;
                end
        for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [N*W-1:0] k);
        @(negedge clk);
        in_valid = v;
        in_keys  = k;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] zo;
        logic [N*W-1:0] rk;
        logic [N*W-1:0] held;

        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 reset valid", {{(N*W-1){1'b0}}, out_valid}, '0);
        check("R7 reset keys", out_keys, '0);
        rst = 1'b0;

        // Table of directed vectors (R1, R3, R4)
        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VEC_IN[i]);
            check(vec_tag(i), out_keys, VEC_EXP[i]);
        end

        // R2: all zero-one patterns
        for (int p = 0; p < (1 << N); p++) begin
            zo = '0;
            for (int b = 0; b < N; b++) zo[b*W] = p[b];
            apply(1'b1, zo);
            check("R2", out_keys, ref_sort(zo));
        end

        // R1: random multi-bit keys
        for (int r = 0; r < 300; r++) begin
            rk = {$urandom, $urandom};
            apply(1'b1, rk);
            check("R1", out_keys, ref_sort(rk));
        end

        // R5: qualifier follows input by one cycle
        apply(1'b1, 64'h0);
        check("R5 valid high", {{(N*W-1){1'b0}}, out_valid}, 64'h1);
        apply(1'b0, 64'h0);
        check("R5 valid low", {{(N*W-1){1'b0}}, out_valid}, 64'h0);

        // R6: keys held while qualifier low
        apply(1'b1, 64'h1122334455667788);
        held = out_keys;
        check("R6 load", held, ref_sort(64'h1122334455667788));
        apply(1'b0, 64'hFFEEDDCCBBAA9988);
        check("R6 hold", out_keys, held);
        apply(1'b0, 64'h0000000000000000);
        check("R6 hold again", out_keys, held);

        // R7: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        check("R7 mid valid", {{(N*W-1){1'b0}}, out_valid}, '0);
        check("R7 mid keys", out_keys, '0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule